// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Macrocell

This block is one output slice of a small programmable logic array. Sixteen input signals are offered to an AND plane in both true and inverted form, giving 32 literal columns. Each of eight product terms can connect to any subset of those columns. The terms are ORed together, an XOR stage optionally inverts the sum, and a final multiplexer takes the output either straight from the polarity stage or from a flip-flop clocked by the block's clock.

All programming lives in an internal fuse chain that is written serially, most significant bit first, through a shift enable and a serial data pin. A commit strobe arms the output. Until it is armed, and whenever the chain is being rewritten, the output is forced low, so a partly loaded map never reaches the pins. A device array is built by placing several of these slices side by side, with some of the sixteen signals driven by neighbouring outputs.

Top module: `pal_macrocell`

## Requirements
- R1: Literal column 2*i carries sig_in[i] and column 2*i+1 carries its complement; a product term is the AND of every column whose fuse bit is 1.
- R2: A product term with no fuse bit set drives 0, and a term that connects both forms of one signal also drives 0.
- R3: The pre-polarity sum is the OR of all eight product terms.
- R4: Fuse bit 0 is the polarity bit: 1 inverts the sum, 0 passes it unchanged.
- R5: Fuse bit 1 is the mode bit: 0 gives a combinational output that follows sig_in with no clock; 1 gives an output equal to the polarity-stage value captured at the previous rising edge, and that output is 0 in the first cycle after arming.
- R6: While fuse_shift_en is high, each rising edge shifts fuse_sdi into bit 0 of the 258-bit chain, so the first bit sent lands in bit 257; the mask of term t, column c sits in bit 2+32*t+c.
- R7: mc_out is 0 from reset until an edge samples fuse_commit high with fuse_shift_en low, and from any edge that samples fuse_shift_en high until the next such commit; shift wins over commit.
- R8: The active-low reset acts at once on the output, is released through a two-stage synchronizer, clears the armed state and the output flop, and leaves the fuse chain contents intact so that a commit alone restores the old function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the fuse chain, arming flag and output flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 16 | Signals offered to the AND plane |
| fuse_shift_en | input | 1 | Shift the fuse chain by one bit per edge |
| fuse_sdi | input | 1 | Serial fuse data, most significant bit first |
| fuse_commit | input | 1 | Arms the output after a load |
| mc_out | output | 1 | Macrocell output |

## Verification
The bench goes after the term corners: an empty term that a careless design would read as a true AND of nothing and drive high, and a term holding both forms of a signal, which must stay low. It checks the column interleave with single-literal terms, so a swapped true and complement column shows up as an inverted term, and checks a full serial load with random maps, where an LSB-first or off-by-one chain scrambles every output. It watches registered mode for a missing or extra cycle of delay and for a stale flop value leaking out on the first armed cycle, and it resets mid-run then commits without reloading, which catches a design that clears the fuse map or leaves the output live through reset.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_NUM_SIG   = 16;
  localparam int PAL_NUM_TERMS = 8;
  localparam int POL_BIT       = 0;
  localparam int MODE_BIT      = 1;
  localparam int MASK_LSB      = 2;

  function automatic int fuse_width(input int nsig, input int nterm);
    return MASK_LSB + nterm * 2 * nsig;
  endfunction
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int WIDTH = 258
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             commit,
  output logic [WIDTH-1:0] fuses,
  output logic             armed
);
  logic [WIDTH-1:0] fuse_q, fuse_d;
  logic             armed_q, armed_d;

  always_comb begin
    fuse_d  = {fuse_q[WIDTH-2:0], sdi};
    armed_d = armed_q;
    if (shift_en)    armed_d = 1'b0;
    else if (commit) armed_d = 1'b1;
  end

  // Fuse storage carries no reset: contents survive a reset pulse.
  always_ff @(posedge clk) begin
    if (shift_en) fuse_q <= fuse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign fuses = fuse_q;
  assign armed = armed_q;
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int NSIG  = 16,
  parameter int NTERM = 8
) (
  input  logic [NSIG-1:0]         sig,
  input  logic [NTERM*2*NSIG-1:0] masks,
  output logic [NTERM-1:0]        terms
);
  localparam int NCOL = 2 * NSIG;

  logic [NCOL-1:0] lits;

  for (genvar i = 0; i < NSIG; i++) begin : g_lit
    assign lits[2*i]   = sig[i];
    assign lits[2*i+1] = ~sig[i];
  end

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    logic [NCOL-1:0] m;
    assign m        = masks[t*NCOL +: NCOL];
    // An unprogrammed term is unused and must not read as a true AND.
    assign terms[t] = (|m) & (&(~m | lits));
  end
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage #(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTERM-1:0] terms,
  input  logic             invert,
  input  logic             reg_mode,
  input  logic             armed,
  output logic             pol_val,
  output logic             out
);
  logic q_reg, q_next;

  assign pol_val = (|terms) ^ invert;

  // Flop is cleared while unarmed so no stale value escapes after commit.
  always_comb begin
    q_next = armed ? pol_val : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_reg <= 1'b0;
    else        q_reg <= q_next;
  end

  assign out = armed & (reg_mode ? q_reg : pol_val);
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int NSIG  = PAL_NUM_SIG,
  parameter int NTERM = PAL_NUM_TERMS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] sig_in,
  input  logic            fuse_shift_en,
  input  logic            fuse_sdi,
  input  logic            fuse_commit,
  output logic            mc_out
);
  localparam int FW    = fuse_width(NSIG, NTERM);
  localparam int MASKW = FW - MASK_LSB;

  logic            sync1_q, sync2_q, rst_q_n;
  logic [FW-1:0]   fuses;
  logic [MASKW-1:0] masks;
  logic [NTERM-1:0] terms;
  logic            armed, invert, reg_mode, pol_val, out_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_q_n = sync2_q;

  pal_fuse_chain #(.WIDTH(FW)) u_chain (
    .clk(clk), .rst_n(rst_q_n), .shift_en(fuse_shift_en), .sdi(fuse_sdi),
    .commit(fuse_commit), .fuses(fuses), .armed(armed)
  );

  assign invert   = fuses[POL_BIT];
  assign reg_mode = fuses[MODE_BIT];
  assign masks    = fuses[FW-1:MASK_LSB];

  pal_and_plane #(.NSIG(NSIG), .NTERM(NTERM)) u_plane (
    .sig(sig_in), .masks(masks), .terms(terms)
  );

  pal_out_stage #(.NTERM(NTERM)) u_out (
    .clk(clk), .rst_n(rst_q_n), .terms(terms), .invert(invert),
    .reg_mode(reg_mode), .armed(armed), .pol_val(pol_val), .out(out_int)
  );

  assign mc_out = out_int;
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
  parameter int NSIG  = 16,
  parameter int NTERM = 8
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic                    fuse_shift_en,
  input logic                    fuse_commit,
  input logic                    mc_out,
  input logic                    armed,
  input logic                    reg_mode,
  input logic                    invert,
  input logic [NTERM-1:0]        terms,
  input logic [NTERM*2*NSIG-1:0] masks
);
  localparam int NCOL = 2 * NSIG;

  AST_SHIFT_BLANKS: assert property (@(posedge clk) disable iff (!rst_q_n)
    fuse_shift_en |=> (mc_out == 1'b0)); // R7

  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fuse_commit && !fuse_shift_en) |=> armed); // R7

  AST_COMB_POLARITY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && !reg_mode) |-> (mc_out == ((|terms) ^ invert))); // R4

  AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && reg_mode && $past(armed)) |-> (mc_out == $past((|terms) ^ invert))); // R5

  for (genvar t = 0; t < NTERM; t++) begin : g_unused
    AST_UNUSED_TERM: assert property (@(posedge clk) disable iff (!rst_q_n)
      (masks[t*NCOL +: NCOL] == '0) |-> !terms[t]); // R2
  end
endmodule

bind pal_macrocell pal_macrocell_chk #(.NSIG(NSIG), .NTERM(NTERM)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .fuse_shift_en(fuse_shift_en),
  .fuse_commit(fuse_commit), .mc_out(mc_out), .armed(armed),
  .reg_mode(reg_mode), .invert(invert), .terms(terms), .masks(masks)
);

// File: tb/pal_macrocell_test.sv
`timescale 1ns/100ps
module pal_macrocell_test;
  localparam int NS = 16;
  localparam int NT = 8;
  localparam int NC = 2 * NS;
  localparam int FW = 2 + NT * NC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] sig_in;
  logic          fuse_shift_en, fuse_sdi, fuse_commit;
  logic          mc_out;

  int checks = 0;
  int fails  = 0;

  logic [NC-1:0] m_mask [NT];
  logic          m_inv, m_reg, m_loaded, m_q;

  always #2.5 clk = ~clk;

  pal_macrocell uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .fuse_shift_en(fuse_shift_en),
    .fuse_sdi(fuse_sdi), .fuse_commit(fuse_commit), .mc_out(mc_out)
  );

  function automatic logic model_pol(input logic [NS-1:0] s);
    logic sum = 1'b0;
    for (int t = 0; t < NT; t++) begin
      logic term;
      term = (m_mask[t] != '0);
      for (int c = 0; c < NC; c++)
        if (m_mask[t][c]) term = term & ((c % 2 == 0) ? s[c/2] : ~s[c/2]);
      sum = sum | term;
    end
    return sum ^ m_inv;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (mc_out !== exp) begin
      fails++;
      $display("FAIL %s: mc_out=%b expected %b", tag, mc_out, exp);
    end
  endtask

  // Inputs are set 1 ns after an edge; compare, then advance the model.
  task automatic step(input string tag);
    logic exp;
    #1;
    exp = !m_loaded ? 1'b0 : (m_reg ? m_q : model_pol(sig_in));
    check(tag, exp);
    @(posedge clk);
    m_q = m_loaded ? model_pol(sig_in) : 1'b0;
    if (fuse_shift_en)    m_loaded = 1'b0;
    else if (fuse_commit) m_loaded = 1'b1;
    #1;
  endtask

  task automatic load_map(input logic [NC-1:0] mk [NT], input logic inv, input logic rg);
    logic [FW-1:0] img;
    img[0] = inv;
    img[1] = rg;
    for (int t = 0; t < NT; t++) img[2 + t*NC +: NC] = mk[t];
    fuse_shift_en = 1'b1;
    for (int b = FW - 1; b >= 0; b--) begin
      fuse_sdi = img[b];
      step("R7");
    end
    fuse_shift_en = 1'b0;
    for (int t = 0; t < NT; t++) m_mask[t] = mk[t];
    m_inv = inv;
    m_reg = rg;
    fuse_commit = 1'b1;
    step("R7");
    fuse_commit = 1'b0;
  endtask

  task automatic run_vecs(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      sig_in = NS'($urandom);
      step(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    logic [NC-1:0] mk [NT];
    rst_n = 1'b0; sig_in = '0; fuse_shift_en = 1'b0; fuse_sdi = 1'b0; fuse_commit = 1'b0;
    m_loaded = 1'b0; m_q = 1'b0; m_inv = 1'b0; m_reg = 1'b0;
    for (int t = 0; t < NT; t++) m_mask[t] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8", 1'b0);
    rst_n = 1'b1;
    repeat (4) step("R8");

    // R2: blank map, then with inversion (R4)
    for (int t = 0; t < NT; t++) mk[t] = '0;
    load_map(mk, 1'b0, 1'b0);
    run_vecs(8, "R2");
    load_map(mk, 1'b1, 1'b0);
    run_vecs(8, "R4");

    // R2: term 0 fully programmed holds both forms of each signal
    mk[0] = '1;
    load_map(mk, 1'b0, 1'b0);
    run_vecs(8, "R2");

    // R1: term 0 = sig3 & ~sig5 (columns 6 and 11)
    mk[0] = '0; mk[0][6] = 1'b1; mk[0][11] = 1'b1;
    load_map(mk, 1'b0, 1'b0);
    for (int v = 0; v < 4; v++) begin
      sig_in = '0; sig_in[3] = v[0]; sig_in[5] = v[1];
      step("R1");
    end

    // R3: term 0 = sig0, term 7 = sig1
    mk[0] = '0; mk[0][0] = 1'b1; mk[7] = '0; mk[7][2] = 1'b1;
    load_map(mk, 1'b0, 1'b0);
    for (int v = 0; v < 4; v++) begin
      sig_in = '0; sig_in[1:0] = 2'(v);
      step("R3");
    end

    // R5: registered, inverted copy of the R1 function
    mk[7] = '0; mk[0] = '0; mk[0][6] = 1'b1; mk[0][11] = 1'b1;
    sig_in = 16'h0008;
    load_map(mk, 1'b1, 1'b1);
    run_vecs(20, "R5");

    // R8: reset while armed, then commit without reload
    rst_n = 1'b0;
    m_loaded = 1'b0; m_q = 1'b0;
    #1;
    check("R8", 1'b0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) step("R8");
    fuse_commit = 1'b1;
    step("R8");
    fuse_commit = 1'b0;
    run_vecs(10, "R8");

    // R6: random maps through the full serial load
    for (int n = 0; n < 40; n++) begin
      for (int t = 0; t < NT; t++) begin
        mk[t] = '0;
        if ($urandom_range(0, 5) != 0)
          for (int k = 0; k < $urandom_range(1, 3); k++) mk[t][$urandom_range(0, NC-1)] = 1'b1;
      end
      load_map(mk, 1'($urandom), 1'($urandom));
      run_vecs(30, "R6");
    end

    report();
  end
endmodule